// File: doc/BRIEF.md
# Material-Selectable Field Update Pipeline

This block advances one Cartesian component of an electric or magnetic field in a three-dimensional finite-difference time-domain solver. Each clock it takes one grid cell: the component's previous value, four neighbouring values of the opposite field, a two-bit material code, five update coefficients and an auxiliary polarization value. After a fixed three-cycle latency it returns the new field value and, for dispersive cells, the new polarization value, ready for write-back. A cell index and a valid flag travel alongside the data, so the caller can match each result to its cell. All arithmetic is signed fixed point.

A solver builds six instances, one for each component of each field. The caller handles memory addressing, coefficient generation, boundary stretching terms and host transfers. Coefficients come in as ports, cell by cell. Any cell may use any material class, and the class may change on every clock without stalling the pipe.

Top module: `fdtd_field_pipe`

## Requirements
- R1: Values are W-bit two's complement with FRAC fraction bits (defaults 36 and 30). Every product is rounded to nearest with ties toward plus infinity: add 2^(FRAC-1) to the full product, then shift right arithmetically by FRAC. The result is then saturated to the W-bit signed range.
- R2: One cell is accepted per clock. The out_valid and out_idx outputs equal the in_valid and in_idx presented three rising edges earlier, and the field and aux results of that cell appear in the same cycle.
- R3: The spatial difference term is D = (in_pa1 - in_pa0) - (in_pb1 - in_pb0), computed exactly and then saturated to W bits.
- R4: Material code 0 (free space or lossy dielectric) gives out_field = sat(rnd(a*old) + rnd(b*D)) and out_aux = 0.
- R5: Material code 1 (dispersive medium) gives out_field = sat(rnd(a*old) + rnd(b*D) - rnd(c*aux_in)) and out_aux = sat(rnd(d*aux_in) + rnd(e*old)).
- R6: Material code 2 (perfect conductor) and the reserved code 3 force both out_field and out_aux to zero, whatever the operands are.
- R7: No result wraps around. Any sum or product outside the signed range is clamped to 2^(W-1)-1 or -2^(W-1).
- R8: While rst is high (sampled on the clock edge, synchronous), out_valid, out_field and out_aux are all zero after each edge, even if in_valid is high.
- R9: Each cell's result uses that cell's own material code, including when back-to-back cells have different codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Cell operands present this cycle |
| in_idx | input | IDXW | Cell tag, returned with the result |
| in_mat | input | 2 | Material code: 0 dielectric, 1 dispersive, 2 conductor, 3 reserved |
| in_old | input | W | Previous value of this field component |
| in_pa1 | input | W | Opposite-field sample, upper side, first axis |
| in_pa0 | input | W | Opposite-field sample, lower side, first axis |
| in_pb1 | input | W | Opposite-field sample, upper side, second axis |
| in_pb0 | input | W | Opposite-field sample, lower side, second axis |
| in_coef_a | input | W | Decay coefficient applied to the old value |
| in_coef_b | input | W | Coefficient applied to the difference term |
| in_coef_c | input | W | Polarization coupling into the field |
| in_coef_d | input | W | Polarization self-decay |
| in_coef_e | input | W | Field drive into the polarization |
| in_aux | input | W | Previous polarization value |
| out_valid | output | 1 | Result present this cycle |
| out_idx | output | IDXW | Tag of the cell in the result |
| out_field | output | W | New field value |
| out_aux | output | W | New polarization value |

## Verification
In the same clock, three cells in the pipe can belong to three different material classes, and any of them can drive its products or sums into saturation. The bench provokes this with a back-to-back stream that cycles through all four codes. The operands come from a pseudo-random generator, and some cells use full-scale values. Every returned cell is compared with an integer model that uses 128-bit arithmetic and selects the class from that cell's own code. A tag that was never issued counts as an error, and so does a cell that never comes back.

// File: rtl/fdtd_fx_pkg.sv
package fdtd_fx_pkg;

   // Material classes; the encoding is visible on in_mat.
   typedef enum logic [1:0] {
      MAT_DIEL = 2'd0,
      MAT_DISP = 2'd1,
      MAT_COND = 2'd2,
      MAT_RSVD = 2'd3
   } mat_e;

   // Register stages from operand capture to result.
   localparam int PIPE_LAT = 3;

   // Number of coefficient-times-operand products per cell.
   localparam int NUM_MUL = 5;

endpackage

// File: rtl/fx_diff_stage.sv
module fx_diff_stage #(
   parameter int W = 36
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] a1,
   input  logic signed [W-1:0] a0,
   input  logic signed [W-1:0] b1,
   input  logic signed [W-1:0] b0,
   output logic signed [W-1:0] d
);
   localparam int EW = W + 2;
   localparam logic signed [EW-1:0] DMAX = {3'b000, {(W-1){1'b1}}};
   localparam logic signed [EW-1:0] DMIN = ~DMAX;

   logic signed [EW-1:0] diff_full;

   // Exact difference; two extra bits cover the worst case.
   always_comb begin
      diff_full = (EW'(a1) - EW'(a0)) - (EW'(b1) - EW'(b0));
   end

   always_ff @(posedge clk) begin
      if (rst)                  d <= '0;
      else if (diff_full > DMAX) d <= DMAX[W-1:0];
      else if (diff_full < DMIN) d <= DMIN[W-1:0];
      else                       d <= diff_full[W-1:0];
   end

   // Equal neighbour pairs must give no spatial drive.
   AST_DIFF_NULL: assert property (@(posedge clk) disable iff (rst)
      (a1 == a0 && b1 == b0) |=> (d == '0)) else $error("diff null");  // R3

endmodule

// File: rtl/fx_mul_rs.sv
module fx_mul_rs #(
   parameter int W    = 36,
   parameter int FRAC = 30
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] x,
   input  logic signed [W-1:0] y,
   output logic signed [W-1:0] q
);
   localparam int PW = 2 * W + 1;
   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
   localparam logic signed [PW-1:0] QMAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [PW-1:0] QMIN = ~QMAX;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] rnd;
   logic signed [PW-1:0] shf;

   always_comb begin
      prod = PW'(x) * PW'(y);
      rnd  = prod + HALF;
      shf  = rnd >>> FRAC;
   end

   always_ff @(posedge clk) begin
      if (rst)             q <= '0;
      else if (shf > QMAX) q <= QMAX[W-1:0];
      else if (shf < QMIN) q <= QMIN[W-1:0];
      else                 q <= shf[W-1:0];
   end

   // A zero operand leaves nothing for rounding to lift.
   AST_MUL_ZERO_OPND: assert property (@(posedge clk) disable iff (rst)
      (x == '0 || y == '0) |=> (q == '0)) else $error("mul zero");  // R1

endmodule

// File: rtl/fx_merge_stage.sv
module fx_merge_stage
   import fdtd_fx_pkg::*;
#(
   parameter int W = 36
) (
   input  logic                clk,
   input  logic                rst,
   input  mat_e                mat,
   input  logic signed [W-1:0] t_decay,
   input  logic signed [W-1:0] t_curl,
   input  logic signed [W-1:0] t_pcoup,
   input  logic signed [W-1:0] t_pdecay,
   input  logic signed [W-1:0] t_pdrive,
   output logic signed [W-1:0] field,
   output logic signed [W-1:0] aux
);
   localparam int EW = W + 2;
   localparam logic signed [EW-1:0] SMAX = {3'b000, {(W-1){1'b1}}};
   localparam logic signed [EW-1:0] SMIN = ~SMAX;

   logic signed [W-1:0]  pcoup_sel;
   logic signed [EW-1:0] fsum;
   logic signed [EW-1:0] psum;

   function automatic logic signed [W-1:0] clamp(input logic signed [EW-1:0] v);
      if (v > SMAX)      return SMAX[W-1:0];
      else if (v < SMIN) return SMIN[W-1:0];
      else               return v[W-1:0];
   endfunction

   always_comb begin
      pcoup_sel = (mat == MAT_DISP) ? t_pcoup : '0;
      fsum      = EW'(t_decay) + EW'(t_curl) - EW'(pcoup_sel);
      psum      = EW'(t_pdecay) + EW'(t_pdrive);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         field <= '0;
         aux   <= '0;
      end else begin
         unique case (mat)
            MAT_DIEL: begin
               field <= clamp(fsum);
               aux   <= '0;
            end
            MAT_DISP: begin
               field <= clamp(fsum);
               aux   <= clamp(psum);
            end
            default: begin
               field <= '0;
               aux   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/fx_tag_delay.sv
module fx_tag_delay #(
   parameter int DEPTH = 3,
   parameter int TW    = 11
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [TW-1:0]              din,
   output logic [DEPTH-1:0][TW-1:0]   taps
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("fx_tag_delay: DEPTH must be at least 1");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_st
         logic [TW-1:0] st;
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst) st <= '0;
               else     st <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst) st <= '0;
               else     st <= g_st[i-1].st;
            end
         end
         assign taps[i] = st;
      end
   endgenerate

endmodule

// File: rtl/fdtd_field_pipe.sv
module fdtd_field_pipe
   import fdtd_fx_pkg::*;
#(
   parameter int W    = 36,
   parameter int FRAC = 30,
   parameter int IDXW = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [IDXW-1:0]     in_idx,
   input  logic [1:0]          in_mat,
   input  logic signed [W-1:0] in_old,
   input  logic signed [W-1:0] in_pa1,
   input  logic signed [W-1:0] in_pa0,
   input  logic signed [W-1:0] in_pb1,
   input  logic signed [W-1:0] in_pb0,
   input  logic signed [W-1:0] in_coef_a,
   input  logic signed [W-1:0] in_coef_b,
   input  logic signed [W-1:0] in_coef_c,
   input  logic signed [W-1:0] in_coef_d,
   input  logic signed [W-1:0] in_coef_e,
   input  logic signed [W-1:0] in_aux,
   output logic                out_valid,
   output logic [IDXW-1:0]     out_idx,
   output logic signed [W-1:0] out_field,
   output logic signed [W-1:0] out_aux
);
   localparam int LAT = PIPE_LAT;
   localparam int TW  = 1 + IDXW + 2;

   generate
      if (FRAC < 1 || FRAC >= W - 1) begin : g_bad_frac
         $error("fdtd_field_pipe: FRAC must lie in 1..W-2");
      end
      if (IDXW < 1) begin : g_bad_idx
         $error("fdtd_field_pipe: IDXW must be positive");
      end
   endgenerate

   // Stage 1: operand capture (the difference is formed in its own stage module).
   logic signed [W-1:0] s1_old, s1_aux;
   logic signed [W-1:0] s1_ca, s1_cb, s1_cc, s1_cd, s1_ce;
   logic signed [W-1:0] s1_diff;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_old <= '0; s1_aux <= '0;
         s1_ca  <= '0; s1_cb  <= '0; s1_cc <= '0; s1_cd <= '0; s1_ce <= '0;
      end else begin
         s1_old <= in_old;    s1_aux <= in_aux;
         s1_ca  <= in_coef_a; s1_cb  <= in_coef_b; s1_cc <= in_coef_c;
         s1_cd  <= in_coef_d; s1_ce  <= in_coef_e;
      end
   end

   fx_diff_stage #(.W(W)) u_diff (
      .clk (clk), .rst (rst),
      .a1  (in_pa1), .a0 (in_pa0), .b1 (in_pb1), .b0 (in_pb0),
      .d   (s1_diff)
   );

   // Stage 2: five rounded, saturated products.
   logic signed [W-1:0] mul_x [NUM_MUL];
   logic signed [W-1:0] mul_y [NUM_MUL];
   logic signed [W-1:0] mul_q [NUM_MUL];

   always_comb begin
      mul_x[0] = s1_ca; mul_y[0] = s1_old;
      mul_x[1] = s1_cb; mul_y[1] = s1_diff;
      mul_x[2] = s1_cc; mul_y[2] = s1_aux;
      mul_x[3] = s1_cd; mul_y[3] = s1_aux;
      mul_x[4] = s1_ce; mul_y[4] = s1_old;
   end

   generate
      for (genvar m = 0; m < NUM_MUL; m++) begin : g_mul
         fx_mul_rs #(.W(W), .FRAC(FRAC)) u_mul (
            .clk (clk), .rst (rst),
            .x   (mul_x[m]), .y (mul_y[m]),
            .q   (mul_q[m])
         );
      end
   endgenerate

   // Tag line: valid, index and material, one tap per stage.
   logic [LAT-1:0][TW-1:0] tag_taps;
   mat_e mat_s2, mat_out;

   fx_tag_delay #(.DEPTH(LAT), .TW(TW)) u_tags (
      .clk  (clk), .rst (rst),
      .din  ({in_valid, in_idx, in_mat}),
      .taps (tag_taps)
   );

   assign mat_s2    = mat_e'(tag_taps[LAT-2][1:0]);
   assign mat_out   = mat_e'(tag_taps[LAT-1][1:0]);
   assign out_valid = tag_taps[LAT-1][TW-1];
   assign out_idx   = tag_taps[LAT-1][IDXW+1:2];

   // Stage 3: class-selected sums.
   fx_merge_stage #(.W(W)) u_merge (
      .clk      (clk), .rst (rst),
      .mat      (mat_s2),
      .t_decay  (mul_q[0]),
      .t_curl   (mul_q[1]),
      .t_pcoup  (mul_q[2]),
      .t_pdecay (mul_q[3]),
      .t_pdrive (mul_q[4]),
      .field    (out_field),
      .aux      (out_aux)
   );

   // Cycles since reset, so that no $past reaches into reset.
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)               warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))) else $error("valid lat");  // R2
   AST_IDX_LAT: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3 && out_valid) |-> (out_idx == $past(in_idx, 3))) else $error("idx lat");  // R2
   AST_COND_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (mat_out == MAT_COND || mat_out == MAT_RSVD))
      |-> (out_field == '0 && out_aux == '0)) else $error("cond zero");  // R6
   AST_AUX_ONLY_DISP: assert property (@(posedge clk) disable iff (rst)
      (out_valid && mat_out != MAT_DISP) |-> (out_aux == '0)) else $error("aux leak");  // R4
   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && out_field == '0 && out_aux == '0)) else $error("reset");  // R8

endmodule

// File: tb/fdtd_field_pipe_tb.sv
module fdtd_field_pipe_tb;
   localparam int W    = 36;
   localparam int FRAC = 30;
   localparam int IDXW = 8;
   localparam int NT   = 1 << IDXW;

   localparam logic signed [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};
   localparam logic signed [W-1:0] ONE  = W'(64'sd1 <<< FRAC);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic                in_valid = 1'b0;
   logic [IDXW-1:0]     in_idx = '0;
   logic [1:0]          in_mat = '0;
   logic signed [W-1:0] in_old = '0, in_pa1 = '0, in_pa0 = '0, in_pb1 = '0, in_pb0 = '0;
   logic signed [W-1:0] in_coef_a = '0, in_coef_b = '0, in_coef_c = '0, in_coef_d = '0, in_coef_e = '0;
   logic signed [W-1:0] in_aux = '0;
   logic                out_valid;
   logic [IDXW-1:0]     out_idx;
   logic signed [W-1:0] out_field, out_aux;

   always #10 clk = ~clk;  // 50 MHz

   fdtd_field_pipe #(.W(W), .FRAC(FRAC), .IDXW(IDXW)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx), .in_mat(in_mat),
      .in_old(in_old), .in_pa1(in_pa1), .in_pa0(in_pa0), .in_pb1(in_pb1), .in_pb0(in_pb0),
      .in_coef_a(in_coef_a), .in_coef_b(in_coef_b), .in_coef_c(in_coef_c),
      .in_coef_d(in_coef_d), .in_coef_e(in_coef_e), .in_aux(in_aux),
      .out_valid(out_valid), .out_idx(out_idx), .out_field(out_field), .out_aux(out_aux)
   );

   int n_checks = 0;
   int n_fails  = 0;
   int outstanding = 0;
   logic [IDXW-1:0] next_idx = '0;
   logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

   logic signed [W-1:0] exp_field [NT];
   logic signed [W-1:0] exp_aux   [NT];
   logic                pending   [NT];
   string               exp_tag   [NT];

   initial for (int i = 0; i < NT; i++) pending[i] = 1'b0;

   function automatic logic signed [W-1:0] sat_ref(input logic signed [127:0] v);
      if (v > 128'(VMAX))      return VMAX;
      else if (v < 128'(VMIN)) return VMIN;
      else                     return v[W-1:0];
   endfunction

   function automatic logic signed [W-1:0] mul_ref(input logic signed [W-1:0] x,
                                                   input logic signed [W-1:0] y);
      logic signed [127:0] p;
      p = 128'(x) * 128'(y);
      p = p + (128'sd1 <<< (FRAC - 1));
      p = p >>> FRAC;
      return sat_ref(p);
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one cell at a falling edge, record its expected result, advance one cycle.
   task automatic send(input string req, input logic [1:0] mat,
                       input logic signed [W-1:0] old, pa1, pa0, pb1, pb0,
                       input logic signed [W-1:0] ca, cb, cc, cd, ce, aux);
      logic signed [W-1:0] dterm, base, f, x;
      dterm = sat_ref((128'(pa1) - 128'(pa0)) - (128'(pb1) - 128'(pb0)));
      base  = '0;
      f = '0; x = '0;
      if (mat == 2'd0) begin
         f = sat_ref(128'(mul_ref(ca, old)) + 128'(mul_ref(cb, dterm)));
      end else if (mat == 2'd1) begin
         f = sat_ref(128'(mul_ref(ca, old)) + 128'(mul_ref(cb, dterm)) - 128'(mul_ref(cc, aux)));
         x = sat_ref(128'(mul_ref(cd, aux)) + 128'(mul_ref(ce, old)));
      end
      base = f;
      exp_field[next_idx] = base;
      exp_aux[next_idx]   = x;
      exp_tag[next_idx]   = req;
      pending[next_idx]   = 1'b1;
      outstanding++;
      in_valid = 1'b1; in_idx = next_idx; in_mat = mat;
      in_old = old; in_pa1 = pa1; in_pa0 = pa0; in_pb1 = pb1; in_pb0 = pb0;
      in_coef_a = ca; in_coef_b = cb; in_coef_c = cc; in_coef_d = cd; in_coef_e = ce;
      in_aux = aux;
      next_idx = next_idx + 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      idle(6);
      check("R2 all cells returned", W'(outstanding), W'(0));
   endtask

   function automatic logic signed [W-1:0] rnd_val(input logic [63:0] r);
      return W'($signed(r[33:0]));
   endfunction

   task automatic step_rng();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 7);
      rs = rs ^ (rs << 17);
   endtask

   // Result monitor: compares every returned cell with its recorded expectation.
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (!pending[out_idx]) begin
            n_checks++; n_fails++;
            $display("FAIL R2: unexpected tag actual %0d expected none", out_idx);
         end else begin
            check({exp_tag[out_idx], " field"}, out_field, exp_field[out_idx]);
            check({exp_tag[out_idx], " aux"},   out_aux,   exp_aux[out_idx]);
            pending[out_idx] = 1'b0;
            outstanding--;
         end
      end
   end

   task automatic t_reset();
      rst = 1'b1;
      in_valid = 1'b1; in_mat = 2'd0; in_old = ONE; in_coef_a = ONE;
      repeat (3) begin
         @(negedge clk);
         check("R8 valid in reset", W'(out_valid), W'(0));
         check("R8 field in reset", out_field, '0);
         check("R8 aux in reset",   out_aux,   '0);
      end
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_latency();
      int cnt;
      send("R2 latency", 2'd0, ONE, '0, '0, '0, '0, ONE, '0, '0, '0, '0, '0);
      in_valid = 1'b0;
      cnt = 1;
      while (!out_valid && cnt < 10) begin
         @(negedge clk);
         cnt++;
      end
      check("R2 latency cycles", W'(cnt), W'(3));
      drain();
   endtask

   task automatic t_rounding();
      // R1: tie rounds up; negative tie rounds to zero; b = 0 removes the difference.
      send("R1 tie pos", 2'd0, W'(64'sd1 <<< (FRAC-1)), '0, '0, '0, '0, W'(1), '0, '0, '0, '0, '0);
      send("R1 tie neg", 2'd0, W'(64'sd1 <<< (FRAC-1)), '0, '0, '0, '0, -W'(1), '0, '0, '0, '0, '0);
      send("R1 below tie", 2'd0, W'((64'sd1 <<< (FRAC-1)) - 1), '0, '0, '0, '0, W'(1), '0, '0, '0, '0, '0);
      drain();
   endtask

   task automatic t_diel();
      // R3: a = 0, b = 1.0 exposes D directly.
      send("R3 diff", 2'd0, ONE, 3*ONE, ONE, -ONE, 2*ONE, '0, ONE, '0, '0, '0, '0);
      send("R3 diff sat", 2'd0, '0, VMAX, VMIN, VMIN, VMAX, '0, ONE, '0, '0, '0, '0);
      // R4: nonzero aux operands must not leak for class 0.
      send("R4 diel", 2'd0, 5*ONE/2, ONE, -ONE/2, ONE/4, ONE/8, ONE/3, ONE/7, ONE, ONE, ONE, 4*ONE);
      send("R4 diel neg", 2'd0, -7*ONE, -ONE, ONE, ONE, -ONE, ONE/5, -ONE/9, ONE, ONE, ONE, -ONE);
      drain();
   endtask

   task automatic t_disp();
      send("R5 disp", 2'd1, 2*ONE, ONE, -ONE, ONE/2, '0, ONE/2, ONE/4, ONE/3, ONE/2, ONE/6, 3*ONE);
      send("R5 disp neg", 2'd1, -ONE, '0, ONE, '0, '0, ONE, ONE/3, -ONE/5, -ONE/7, ONE/9, -2*ONE);
      drain();
   endtask

   task automatic t_cond();
      send("R6 conductor", 2'd2, 3*ONE, ONE, -ONE, ONE, ONE, ONE, ONE, ONE, ONE, ONE, ONE);
      send("R6 reserved", 2'd3, -3*ONE, VMAX, VMIN, '0, '0, VMAX, VMAX, VMAX, VMAX, VMAX, VMAX);
      drain();
   endtask

   task automatic t_saturate();
      send("R7 pos sat", 2'd0, VMAX, VMAX, VMIN, VMIN, VMAX, VMAX, VMAX, '0, '0, '0, '0);
      send("R7 neg sat", 2'd0, VMIN, VMIN, VMAX, VMAX, VMIN, VMAX, VMAX, '0, '0, '0, '0);
      send("R7 disp sat", 2'd1, VMAX, '0, '0, '0, '0, VMAX, '0, VMIN, VMAX, VMAX, VMAX);
      send("R7 disp negsat", 2'd1, VMIN, '0, '0, '0, '0, VMAX, '0, VMAX, VMAX, VMAX, VMAX);
      drain();
   endtask

   task automatic t_stream();
      // R9: material changes on every clock, occasional bubbles and full-scale cells.
      for (int i = 0; i < 120; i++) begin
         logic signed [W-1:0] v [12];
         for (int k = 0; k < 12; k++) begin
            step_rng();
            v[k] = (k >= 5 && k <= 9) ? W'($signed(rs[31:0])) : rnd_val(rs);
         end
         if (i % 17 == 5) begin
            v[0] = VMAX; v[5] = VMAX; v[7] = VMIN; v[11] = VMAX;
         end
         send("R9 stream", 2'(i % 4), v[0], v[1], v[2], v[3], v[4],
              v[5], v[6], v[7], v[8], v[9], v[11]);
         if (i % 11 == 10) idle(1);
      end
      drain();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_latency();
      t_rounding();
      t_diel();
      t_disp();
      t_cond();
      t_saturate();
      t_stream();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule